// File: doc/BRIEF.md
# Quasi-Bidirectional Port Drive Sequencer

This block owns the output register of an eight-pin quasi-bidirectional I/O port and turns each register bit into three drive enables for the pad: a strong pulldown, a short strong pullup and a weak keeper pullup. A pin whose register bit is 1 is held high only by the weak keeper. External logic can then overpower it, so the same pin also works as an input.

Software writes the whole register through a single strobe with data. The block sequences every bit on its own. A bit written to 0 pulls its pin down hard and keeps doing so. A bit that changes from 0 to 1 drives the pin high strongly for two clocks to speed up the rising edge, and then hands over to the keeper. Two read paths are provided. The register contents come back unchanged, and the pin levels come back through a two-flop synchronizer.

Top module: `qbio_port_ctrl`

## Requirements
- R1: While reset is active and after it is released with no write, every register bit reads 1, no pin has its strong pulldown or strong pullup enabled, every pin has its weak pullup enabled, and every synchronized pin bit reads 1.
- R2: `latch_rd` changes only on a clock edge where `wr_en` is 1, and after such an edge it equals `wr_data`.
- R3: After an edge that writes 0 to a bit, that bit's `drv_pulldown` is 1 and its `drv_strong_up` and `drv_weak_up` are 0. This holds until a later edge writes 1 to the same bit.
- R4: After an edge that writes 1 to a bit whose register value was 0, `drv_strong_up` for that bit is 1 for exactly two clock cycles and is then 0.
- R5: `drv_weak_up` for a bit is 1 exactly when its register bit is 1 and no strong pullup pulse is active on it.
- R6: Writing 1 to a bit that already holds 1 starts no new pulse. An idle bit stays idle, and a running pulse keeps its original end cycle.
- R7: `drv_pulldown` and `drv_strong_up` are never 1 together on any bit, including the cycle after a 1 is written over a 0.
- R8: Writing 0 to a bit while its pulse is active clears `drv_strong_up` and sets `drv_pulldown` at that same clock edge.
- R9: `pin_rd` equals `pin_in` as it was two clock edges earlier.
- R10: Each bit is sequenced independently, so pulses and pulldowns on different bits can overlap in any combination within one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Value written to the port register |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| latch_rd | output | 8 | Register contents |
| pin_rd | output | 8 | Synchronized pad levels |
| drv_pulldown | output | 8 | Strong pulldown enable per pin |
| drv_strong_up | output | 8 | Momentary strong pullup enable per pin |
| drv_weak_up | output | 8 | Weak keeper pullup enable per pin |

## Verification
The hardest cases to reach are writes that land inside a two-cycle pullup pulse. These are a 0 that cuts the pulse short, a repeated 1 that must not stretch it, and a rewrite on the very edge where the pulse ends. Each one needs back-to-back strobes with the bit flipping in a precise phase. The stimulus reaches them with directed sequences of 0→1 writes followed by writes on the next one or two cycles. It then adds long stretches of random writes on consecutive cycles, with a mask that biases the data toward toggling, so every bit passes through every phase of the pulse. A behavioural model in the bench predicts all outputs and is compared with the design on every clock.

// File: rtl/qbio_pkg.sv
package qbio_pkg;

    // Pulse counter width; PULSE_CLKS must fit in it.
    localparam int CNT_W = 4;

    typedef logic [CNT_W-1:0] pulse_cnt_t;

    // Register state of one pin
    typedef struct packed {
        logic       lat;
        pulse_cnt_t cnt;
    } pin_state_t;

endpackage

// File: rtl/qbio_pin_seq.sv
module qbio_pin_seq
    import qbio_pkg::*;
#(
    parameter int unsigned PULSE_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic lat_o,
    output logic pd_o,
    output logic su_o,
    output logic wk_o
);

    localparam pulse_cnt_t PULSE_LOAD = pulse_cnt_t'(PULSE_CLKS);

    pin_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - pulse_cnt_t'(1);
        end
        if (wr_en) begin
            if (!wr_bit) begin
                st_d.lat = 1'b0;
                st_d.cnt = '0;
            end else if (!st_q.lat) begin
                st_d.lat = 1'b1;
                st_d.cnt = PULSE_LOAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lat <= 1'b1;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_o = st_q.lat;
    assign su_o  = (st_q.cnt != '0);
    assign pd_o  = ~st_q.lat;
    assign wk_o  = st_q.lat & ~su_o;

    // R7: strong drivers never fight
    p_no_fight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pd_o && su_o));

    // R4: a rising write loads a full pulse
    p_rise_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bit && !st_q.lat) |=> (su_o && !pd_o && st_q.cnt == PULSE_LOAD));

    // R4: the last pulse cycle is followed by no pulse
    p_pulse_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == pulse_cnt_t'(1)) |=> !su_o);

    // R6: rewriting a 1 on an idle bit starts nothing
    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bit && st_q.lat && !su_o) |=> (!su_o && wk_o));

    // R3 / R8: a 0 write drives the pulldown only
    p_zero_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bit) |=> (pd_o && !su_o && !wk_o));

    // R2: no strobe, no register change
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(lat_o));

endmodule

// File: rtl/qbio_sync.sv
module qbio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int AGE_W = $clog2(STAGES + 1);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } sync_state_t;

    sync_state_t sy_d, sy_q;

    always_comb begin
        sy_d = sy_q;
        sy_d.stg[0] = async_i;
        for (int k = 1; k < int'(STAGES); k++) begin
            sy_d.stg[k] = sy_q.stg[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '1;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign sync_o = sy_q.stg[STAGES-1];

    // Edges since reset, saturating, so the check below never looks past reset
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != AGE_W'(STAGES)) begin
            age_q <= age_q + AGE_W'(1);
        end
    end

    // R9: output is the input delayed by STAGES edges
    p_sync_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == AGE_W'(STAGES)) |-> (sync_o == $past(async_i, STAGES)));

endmodule

// File: rtl/qbio_port_ctrl.sv
module qbio_port_ctrl
    import qbio_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned PULSE_CLKS  = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] latch_rd,
    output logic [WIDTH-1:0] pin_rd,
    output logic [WIDTH-1:0] drv_pulldown,
    output logic [WIDTH-1:0] drv_strong_up,
    output logic [WIDTH-1:0] drv_weak_up
);

    // R10: one independent sequencer per pin
    for (genvar i = 0; i < int'(WIDTH); i++) begin : g_pin
        qbio_pin_seq #(
            .PULSE_CLKS(PULSE_CLKS)
        ) u_seq (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en),
            .wr_bit (wr_data[i]),
            .lat_o  (latch_rd[i]),
            .pd_o   (drv_pulldown[i]),
            .su_o   (drv_strong_up[i]),
            .wk_o   (drv_weak_up[i])
        );
    end

    qbio_sync #(
        .WIDTH (WIDTH),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_in),
        .sync_o (pin_rd)
    );

    // R2: register follows a write on the next edge
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (latch_rd == $past(wr_data)));

    // R5: each pin has exactly one pull source: pulldown, strong up or keeper
    p_one_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_pulldown ^ drv_strong_up ^ drv_weak_up) == '1) &&
        ((drv_pulldown & drv_weak_up) == '0) &&
        ((drv_strong_up & drv_weak_up) == '0));

endmodule

// File: tb/tb_qbio_port_ctrl.sv
`timescale 1ns/1ps
module tb_qbio_port_ctrl;

    localparam int W = 8;
    localparam int PULSE = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] pin_in = '1;
    logic [W-1:0] latch_rd, pin_rd, drv_pulldown, drv_strong_up, drv_weak_up;

    int vectors = 0;
    int miscompares = 0;

    // reference state
    int m_lat [W];
    int m_cnt [W];
    logic [W-1:0] m_pin_q [$];

    always #4 clk = ~clk;

    qbio_port_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .pin_in       (pin_in),
        .latch_rd     (latch_rd),
        .pin_rd       (pin_rd),
        .drv_pulldown (drv_pulldown),
        .drv_strong_up(drv_strong_up),
        .drv_weak_up  (drv_weak_up)
    );

    task automatic model_reset();
        for (int i = 0; i < W; i++) begin
            m_lat[i] = 1;
            m_cnt[i] = 0;
        end
        m_pin_q.delete();
        m_pin_q.push_back('1);
        m_pin_q.push_back('1);
    endtask

    task automatic model_step(input logic we, input logic [W-1:0] wd, input logic [W-1:0] pi);
        for (int i = 0; i < W; i++) begin
            int nl = m_lat[i];
            int nc = (m_cnt[i] > 0) ? m_cnt[i] - 1 : 0;
            if (we) begin
                if (!wd[i]) begin
                    nl = 0; nc = 0;
                end else if (m_lat[i] == 0) begin
                    nl = 1; nc = PULSE;
                end
            end
            m_lat[i] = nl;
            m_cnt[i] = nc;
        end
        m_pin_q.push_back(pi);
        void'(m_pin_q.pop_front());
    endtask

    task automatic compare(input string tag);
        logic [W-1:0] e_lat, e_pd, e_su, e_wk;
        bit bad = 0;
        for (int i = 0; i < W; i++) begin
            e_lat[i] = (m_lat[i] != 0);
            e_pd[i]  = (m_lat[i] == 0);
            e_su[i]  = (m_cnt[i] != 0);
            e_wk[i]  = (m_lat[i] != 0) && (m_cnt[i] == 0);
        end
        vectors++;
        if (latch_rd !== e_lat) begin
            $display("FAIL %s R2 latch_rd actual %h expected %h", tag, latch_rd, e_lat); bad = 1;
        end
        if (drv_pulldown !== e_pd) begin
            $display("FAIL %s R3 drv_pulldown actual %h expected %h", tag, drv_pulldown, e_pd); bad = 1;
        end
        if (drv_strong_up !== e_su) begin
            $display("FAIL %s R4 drv_strong_up actual %h expected %h", tag, drv_strong_up, e_su); bad = 1;
        end
        if (drv_weak_up !== e_wk) begin
            $display("FAIL %s R5 drv_weak_up actual %h expected %h", tag, drv_weak_up, e_wk); bad = 1;
        end
        if ((drv_pulldown & drv_strong_up) !== '0) begin
            $display("FAIL %s R7 overlap actual %h expected 00", tag, drv_pulldown & drv_strong_up); bad = 1;
        end
        if (pin_rd !== m_pin_q[0]) begin
            $display("FAIL %s R9 pin_rd actual %h expected %h", tag, pin_rd, m_pin_q[0]); bad = 1;
        end
        if (bad) miscompares++;
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input logic we, input logic [W-1:0] wd, input logic [W-1:0] pi, input string tag);
        wr_en = we; wr_data = wd; pin_in = pi;
        @(posedge clk);
        model_step(we, wd, pi);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(1'b0, $urandom, pin_in, tag);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        miscompares++;
        $display("FAIL watchdog expired actual running expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        logic [W-1:0] d;
        void'($urandom(32'h5eed));
        model_reset();
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        idle(3, "R1 after reset");

        // R3: zeros pull down and hold
        cyc(1'b1, 8'h00, 8'hA5, "R3 all zero");
        idle(4, "R3 hold");
        // R4: rise on all bits, pulse two cycles
        cyc(1'b1, 8'hFF, 8'h5A, "R4 all rise");
        idle(4, "R4 pulse tail");
        // R6: rewrite 1 over idle 1
        cyc(1'b1, 8'hFF, 8'h3C, "R6 idle rewrite");
        idle(2, "R6 idle");
        // R6: rewrite during pulse does not stretch
        cyc(1'b1, 8'h00, 8'h00, "R6 setup");
        cyc(1'b1, 8'hFF, 8'hFF, "R6 rise");
        cyc(1'b1, 8'hFF, 8'h0F, "R6 mid-pulse rewrite");
        idle(3, "R6 no stretch");
        // R8: zero during pulse
        cyc(1'b1, 8'h00, 8'hF0, "R8 setup");
        cyc(1'b1, 8'hFF, 8'hF0, "R8 rise");
        cyc(1'b1, 8'h00, 8'h11, "R8 cut pulse");
        idle(2, "R8 pulldown");
        // R8 on second pulse cycle, then rise again on the pulse's last edge
        cyc(1'b1, 8'hFF, 8'h22, "R8 rise2");
        cyc(1'b1, 8'hFF, 8'h22, "R8 keep");
        cyc(1'b1, 8'h00, 8'h44, "R8 late cut");
        cyc(1'b1, 8'hFF, 8'h44, "R4 re-rise");
        idle(3, "R4 tail");
        // R10: mixed patterns per bit
        cyc(1'b1, 8'hA5, 8'h81, "R10 mix a");
        cyc(1'b1, 8'h5A, 8'h18, "R10 mix b");
        cyc(1'b1, 8'hF0, 8'h7E, "R10 mix c");
        cyc(1'b1, 8'h0F, 8'hE7, "R10 mix d");
        idle(3, "R10 settle");
        // R9: pin pattern walk
        for (int i = 0; i < W; i++) cyc(1'b0, 8'h00, 8'(1 << i), "R9 walk");
        // random back-to-back writes, biased toward toggling
        for (int n = 0; n < 3000; n++) begin
            d = $urandom;
            if (($urandom % 4) == 0) d = ~latch_rd;
            cyc(($urandom % 4) != 0, d, $urandom, "R10 random");
        end
        // R1: reset mid-run restores idle state
        cyc(1'b1, 8'h00, 8'h00, "R1 pre");
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        compare("R1 async reset");
        rst_n = 1'b1;
        idle(3, "R1 post");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule